// File: doc/BRIEF.md
# Clock Reference Select and Bus Clock Divider

This unit is the control side of a chip clock generator. Software reaches it through two byte-wide registers. The first register holds three controls. One picks which reference feeds the frequency-locked loop: the on-chip reference or an external one. One turns on the internal reference clock output. One decides whether that reference may keep running while the chip is in stop mode. The second register holds a three-bit ratio field. The ratio turns the selected clock into a bus clock enable that fires once every 2^n cycles.

Stop handling follows a combined rule. While stop is active, the internal reference stays on only if the stop-keep control is set and at least one of two conditions holds: the clock-output enable is set, or the clock unit was running from the internal reference at the moment stop began. The unit captures the mode indication on the cycle stop is first seen. It holds that captured value until stop is released, so the rule is judged against the mode that was in force before stop. The loop itself and the oscillators lie outside this block.

Top module: `clkref_ctrl`

## Requirements
- R1: `ref_int_sel` equals bit 0 of control register A (address 0). A value of 1 selects the internal reference and 0 selects the external one. It resets to 1.
- R2: Control register A keeps its fields at bit 0 (reference select), bit 1 (clock-output enable) and bit 2 (stop keep). It resets to 0x01. Writes to bits 7..3 have no effect, and those bits read as 0.
- R3: Outside stop, `irc_on` equals the clock-output enable bit.
- R4: `stop_req` is registered once. The unit is in stop from the edge that samples `stop_req` high up to the edge that samples it low. In stop with stop keep at 0, `irc_on` is 0.
- R5: In stop with stop keep at 1, `irc_on` is 1 exactly when the clock-output enable bit is 1 or the captured mode is 1.
- R6: The mode is captured from `mode_int_ref` on the edge that enters stop. Changes on `mode_int_ref` while stop lasts have no effect on `irc_on`.
- R7: Control register B (address 1) holds the ratio field n in bits 7..5. It resets to 0x20 (n = 1). Bits 4..0 ignore writes and read as 0.
- R8: `bus_ce` is a one-cycle pulse with period 2^n cycles. When n = 0, `bus_ce` is high on every cycle.
- R9: A write to register B restarts the ratio count. After the write edge, the first pulse comes in the cycle that follows the (2^n)-th edge, counting the write edge as the first.
- R10: On an edge with `reg_rd` high, `reg_rdata` loads the value the addressed register held before that edge. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop mode request |
| mode_int_ref | input | 1 | High while the clock unit runs from the internal reference |
| reg_addr | input | ADDR_W | Register select: 0 = control A, 1 = control B |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ref_int_sel | output | 1 | Reference select (1 = internal) |
| irc_on | output | 1 | Internal reference enable |
| bus_ce | output | 1 | Bus clock enable pulse |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a one-bit address and a 3-bit ratio field, which gives a 7-bit counter. With these values the bench can step through every ratio from 1 to 128 within a few hundred cycles, and it sees the widest ratio complete whole periods. It also runs through all eight combinations of stop keep, clock-output enable and captured mode. The mode input is toggled during stop, and register A is written while stop is held.

// File: rtl/clkref_pkg.sv
package clkref_pkg;

  typedef struct packed {
    logic stop_keep;
    logic irc_en;
    logic ref_int;
  } ctrl_a_t;

  localparam int CTRL_A_W = $bits(ctrl_a_t);

  localparam ctrl_a_t CTRL_A_RST = '{stop_keep: 1'b0, irc_en: 1'b0, ref_int: 1'b1};

  localparam int SEL_CTRL_A = 0;
  localparam int SEL_CTRL_B = 1;
  localparam int DIV_RST    = 1;

  // Stop-mode survival rule for the internal reference.
  function automatic logic keep_alive(ctrl_a_t c, logic mode_int);
    return c.stop_keep & (c.irc_en | mode_int);
  endfunction

endpackage

// File: rtl/clkref_regs.sv
module clkref_regs
  import clkref_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_a_t           ctrl,
  output logic [DIV_W-1:0]  div_sel,
  output logic              div_restart,
  output logic [DATA_W-1:0] rdata
);

  localparam int DIV_LSB = DATA_W - DIV_W;

  ctrl_a_t           ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_a, hit_b;
  logic [DATA_W-1:0] read_mux;
  logic              unused_wbits;

  assign hit_a        = (addr == ADDR_W'(SEL_CTRL_A));
  assign hit_b        = (addr == ADDR_W'(SEL_CTRL_B));
  assign div_restart  = wr_en & hit_b;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_A_RST;
      div_q  <= DIV_W'(DIV_RST);
    end else if (wr_en) begin
      if (hit_a) ctrl_q <= ctrl_a_t'(wdata[CTRL_A_W-1:0]);
      if (hit_b) div_q  <= wdata[DATA_W-1 -: DIV_W];
    end
  end

  always_comb begin
    read_mux = '0;
    if (hit_a)      read_mux = DATA_W'(ctrl_q);
    else if (hit_b) read_mux = {div_q, {DIV_LSB{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= read_mux;
  end

  assign ctrl    = ctrl_q;
  assign div_sel = div_q;
  assign rdata   = rdata_q;

  // R7
  div_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_restart |=> div_sel == $past(wdata[DATA_W-1 -: DIV_W]));

  // R7
  div_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_b) |=> rdata[DIV_LSB-1:0] == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/clkref_stop.sv
module clkref_stop
  import clkref_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_req,
  input  logic    mode_int,
  input  ctrl_a_t ctrl,
  output logic    in_stop,
  output logic    mode_held,
  output logic    irc_on
);

  logic stop_q;
  logic mode_q;
  logic stop_entry;

  assign stop_entry = stop_req & ~stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      stop_q <= stop_req;
      if (stop_entry) mode_q <= mode_int;
    end
  end

  assign in_stop   = stop_q;
  assign mode_held = mode_q;
  assign irc_on    = stop_q ? keep_alive(ctrl, mode_q) : ctrl.irc_en;

  // R6
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> mode_held == $past(mode_int));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && stop_req) |=> $stable(mode_held));

  // R4
  stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !ctrl.stop_keep) |-> !irc_on);

  // R5
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && ctrl.stop_keep && ctrl.irc_en) |-> irc_on);

endmodule

// File: rtl/clkref_div.sv
module clkref_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             restart,
  output logic             bus_ce
);

  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ones_upto;
  logic             ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // ones_upto[i] is high when counter bits i..0 are all ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_ones
    if (i == 0) begin : g_first
      assign ones_upto[i] = cnt_q[0];
    end else begin : g_next
      assign ones_upto[i] = ones_upto[i-1] & cnt_q[i];
    end
  end

  always_comb begin
    if (div_sel == '0) ce = 1'b1;
    else               ce = ones_upto[div_sel - DIV_W'(1)];
  end

  assign bus_ce = ce;

  // R8
  ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && div_sel != '0 && !restart) |=> !bus_ce);

  // R8
  ce_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |-> bus_ce);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> bus_ce == (div_sel == '0));

endmodule

// File: rtl/clkref_ctrl.sv
module clkref_ctrl
  import clkref_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              mode_int_ref,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ref_int_sel,
  output logic              irc_on,
  output logic              bus_ce
);

  ctrl_a_t          ctrl;
  logic [DIV_W-1:0] div_sel;
  logic             div_restart;
  logic             in_stop;
  logic             mode_held;
  logic             unused_stop_view;

  clkref_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (reg_addr),
    .wr_en      (reg_wr),
    .rd_en      (reg_rd),
    .wdata      (reg_wdata),
    .ctrl       (ctrl),
    .div_sel    (div_sel),
    .div_restart(div_restart),
    .rdata      (reg_rdata)
  );

  clkref_stop u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .mode_int (mode_int_ref),
    .ctrl     (ctrl),
    .in_stop  (in_stop),
    .mode_held(mode_held),
    .irc_on   (irc_on)
  );

  clkref_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_sel(div_sel),
    .restart(div_restart),
    .bus_ce (bus_ce)
  );

  assign ref_int_sel      = ctrl.ref_int;
  assign unused_stop_view = in_stop ^ mode_held;

  // R1
  ref_sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(SEL_CTRL_A)) |=> ref_int_sel == $past(reg_wdata[0]));

  // R3
  run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stop && !$past(reg_wr)) |-> irc_on == $past(irc_on) || $rose(in_stop) || $fell(in_stop));

endmodule

// File: tb/tb_clkref_ctrl.sv
module tb_clkref_ctrl;

  localparam int PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stop_req = 1'b0;
  logic              mode_int_ref = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              ref_int_sel, irc_on, bus_ce;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(PERIOD/2) clk = ~clk;

  clkref_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mode_int_ref(mode_int_ref),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ref_int_sel(ref_int_sel), .irc_on(irc_on), .bus_ce(bus_ce)
  );

  // Behavioural reference model
  bit m_ref, m_en, m_keep, m_stop, m_mode;
  int m_div, m_ticks, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 1; m_en = 0; m_keep = 0; m_stop = 0; m_mode = 0;
      m_div = 1; m_ticks = 0; m_rdata = 0;
    end else begin
      if (reg_rd)
        m_rdata = (reg_addr == 0) ? (m_keep * 4 + m_en * 2 + m_ref) : (m_div * 32);
      if (reg_wr && reg_addr == 1) m_ticks = 0;
      else m_ticks = m_ticks + 1;
      if (reg_wr && reg_addr == 0) begin
        m_ref = reg_wdata[0]; m_en = reg_wdata[1]; m_keep = reg_wdata[2];
      end
      if (reg_wr && reg_addr == 1) m_div = int'(reg_wdata) / 32;
      if (stop_req && !m_stop) m_mode = mode_int_ref;
      m_stop = stop_req;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ratio;
      bit exp_irc;
      string irc_tag;
      ratio = 1 << m_div;
      if (m_stop) begin
        exp_irc = m_keep && (m_en || m_mode);
        irc_tag = m_keep ? "R5 R6 irc_on" : "R4 irc_on";
      end else begin
        exp_irc = m_en;
        irc_tag = "R3 irc_on";
      end
      check("R1 ref_int_sel", ref_int_sel, m_ref);
      check(irc_tag, irc_on, exp_irc);
      check("R8 R9 bus_ce", bus_ce, (m_ticks % ratio) == ratio - 1);
      check("R2 R7 R10 reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk); #1;
    reg_rd = 1; reg_addr = ADDR_W'(a);
    @(negedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic set_stop(bit s);
    @(negedge clk); #1;
    stop_req = s;
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1;
    rd(0); rd(1); idle(10);                  // R2 R7 reset values
    for (int d = 0; d < 8; d++) begin        // R8 R9 every ratio, spare bits set
      wr(1, d * 32 + 31);
      rd(1);
      idle((1 << d) * 2 + 3);
    end
    wr(1, 3 * 32); idle(3); wr(1, 3 * 32); idle(20);  // R9 restart mid-count
    for (int v = 0; v < 8; v++) begin        // R1 R2 R3 all control values
      wr(0, v + 8'hF8);
      rd(0);
      idle(2);
    end
    for (int k = 0; k < 8; k++) begin        // R4 R5 R6 stop combinations
      wr(0, (k & 3) * 2 + 1);
      @(negedge clk); #1 mode_int_ref = k[2];
      set_stop(1); idle(3);
      @(negedge clk); #1 mode_int_ref = ~k[2];
      idle(3);
      set_stop(0); idle(2);
    end
    mode_int_ref = 0;
    wr(0, 4); set_stop(1); idle(2);          // R5 writes while stopped
    wr(0, 6); idle(2);
    wr(0, 2); idle(2);
    set_stop(0); idle(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule